// File: doc/BRIEF.md
# Command Strobe One-Shot Synchronizer

This block sits between a slow host, which drives general-purpose pins with no particular timing relation to a fast memory clock, and a memory device that acts on every clock edge in which its command strobe is low. Each host request is an asynchronous, active-low level that may stay asserted for many memory clock cycles. The block re-times that level to the memory clock and shortens it to a strobe that is low for exactly one memory clock period. This makes commands that must not repeat (initialization steps, refresh, precharge) safe to issue from software that only toggles pins.

Every lane also has an active-low bypass input. While bypass is asserted, the lane passes the re-timed host level through at full length. This lets commands that may repeat, such as writes, run for as many cycles as the host holds the request. The same lane circuit serves a chip-select line or a clock-enable line. The lane count is a parameter, and the lanes are fully independent of each other. Each lane has a synchronizer on the request, a synchronizer on the bypass, and an edge stage. The edge stage compares the synchronized request with a registered copy of it and drives a registered output.

Top module: `strb_oneshot`

## Requirements
- R1: While rst_ni is low, every strobe_no bit is high and all synchronizer stages read inactive. A request that is already held low when reset is released is therefore seen as new and yields one pulse.
- R2: With bypass inactive, a request held low for any number of cycles of at least one produces exactly one low cycle on that lane's strobe_no.
- R3: With the default two synchronizer stages, take a request first sampled low at rising edge n. strobe_no goes low after edge n+2 and returns high after edge n+3.
- R4: After a pulse, no further pulse occurs until the synchronized request has been sampled inactive at least once. A host gap of a single cycle between two requests yields two pulses.
- R5: While bypass is active, strobe_no follows the synchronized request level one cycle later. A request held for H cycles gives H low cycles.
- R6: Releasing bypass while the request is still held low ends the low output and causes no extra pulse.
- R7: Each lane acts only on its own req_ni and byp_ni bits. A request on one lane leaves the other lanes' strobe_no high.
- R8: A request that is low for only one clock cycle still produces one full low cycle on strobe_no.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | NUM_LINES | Asynchronous host request per lane, active low |
| byp_ni | input | NUM_LINES | Asynchronous bypass per lane, active low (pass request through at full length) |
| strobe_no | output | NUM_LINES | Command strobe per lane, active low |

## Verification
The assertions take the synchronized request and bypass levels as their reference. They assume that each host input holds steady for at least one full clock period, so that every level change is captured by the synchronizer rather than resolved by a metastable flop. The bench changes req_ni and byp_ni only on falling clock edges and holds each value for whole cycles. Before a request starts, it lets a bypass change settle for several cycles. The only exception is the deliberate release of bypass in the middle of a held request.

// File: rtl/strb_pkg.sv
package strb_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned LINES_DEF      = 2;

  typedef enum logic {
    MODE_SHOT = 1'b0,
    MODE_PASS = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/strb_sync.sv
module strb_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/strb_shot.sv
module strb_shot
  import strb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic byp_i,
  output logic strobe_no
);
  lane_mode_e mode;
  logic seen_q, fire_q, fire_d;

  assign mode = byp_i ? MODE_PASS : MODE_SHOT;

  always_comb begin
    unique case (mode)
      MODE_PASS: fire_d = req_i;
      default:   fire_d = req_i & ~seen_q;
    endcase
  end

  // seen_q tracks the request in every mode so a bypass release mid-request stays quiet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      seen_q <= req_i;
      fire_q <= fire_d;
    end
  end

  assign strobe_no = ~fire_q;
endmodule

// File: rtl/strb_oneshot.sv
module strb_oneshot
  import strb_pkg::*;
#(
  parameter int unsigned NUM_LINES  = LINES_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_ni,
  input  logic [NUM_LINES-1:0] byp_ni,
  output logic [NUM_LINES-1:0] strobe_no
);
  logic [NUM_LINES-1:0] req_s;
  logic [NUM_LINES-1:0] byp_s;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_lane
    strb_sync #(.DEPTH(SYNC_DEPTH)) u_req_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (~req_ni[l]),
      .q_o   (req_s[l])
    );

    strb_sync #(.DEPTH(SYNC_DEPTH)) u_byp_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (~byp_ni[l]),
      .q_o   (byp_s[l])
    );

    strb_shot u_shot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_s[l]),
      .byp_i    (byp_s[l]),
      .strobe_no(strobe_no[l])
    );
  end
endmodule

// File: rtl/strb_oneshot_chk.sv
module strb_oneshot_chk #(
  parameter int unsigned NUM_LINES = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] strobe_no,
  input logic [NUM_LINES-1:0] req_s,
  input logic [NUM_LINES-1:0] byp_s
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (&strobe_no));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    assert_single_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strobe_no[l] && !$past(strobe_no[l])) |-> $past(byp_s[l]));

    assert_pulse_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(req_s[l]) && !byp_s[l]) |=> !strobe_no[l]);

    assert_pulse_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!strobe_no[l] && !byp_s[l]) |=> strobe_no[l]);

    assert_pass_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(byp_s[l]) |-> (strobe_no[l] == !$past(req_s[l])));

    assert_release_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(byp_s[l]) && req_s[l] && $past(req_s[l])) |=> strobe_no[l]);
  end
endmodule

bind strb_oneshot strb_oneshot_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_no(strobe_no),
  .req_s    (req_s),
  .byp_s    (byp_s)
);

// File: tb/strb_oneshot_test.sv
module strb_oneshot_test;
  localparam int LINES = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LINES-1:0] req_ni = '1;
  logic [LINES-1:0] byp_ni = '1;
  logic [LINES-1:0] strobe_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  strb_oneshot #(.NUM_LINES(LINES), .SYNC_DEPTH(2)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_ni   (req_ni),
    .byp_ni   (byp_ni),
    .strobe_no(strobe_no)
  );

  // lane, bypass, hold cycles, expected low cycles
  localparam int NVEC = 10;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 1, 1}, '{0, 0, 2, 1}, '{0, 0, 7, 1}, '{0, 0, 40, 1}, '{1, 0, 5, 1},
    '{1, 0, 1, 1}, '{0, 1, 1, 1}, '{0, 1, 4, 4}, '{1, 1, 9, 9}, '{1, 1, 30, 30}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk_i);
  endtask

  // drive a request for hold cycles plus a quiet tail, counting low cycles per lane
  task automatic run_req(input int lane, input int hold, input int tail,
                         output int lows_own, output int lows_other);
    lows_own = 0;
    lows_other = 0;
    for (int c = 0; c < hold + tail; c++) begin
      req_ni[lane] = (c < hold) ? 1'b0 : 1'b1;
      @(negedge clk_i);
      if (!strobe_no[lane])     lows_own++;
      if (!strobe_no[1 - lane]) lows_other++;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int own, other, hits;
    idle(3);
    chk("R1 strobe high in reset", int'(strobe_no), 3);
    rst_ni = 1'b1;
    run_req(0, 0, 6, own, other);
    chk("R1 no pulse after reset", own + other, 0);

    for (int v = 0; v < NVEC; v++) begin
      byp_ni[VEC[v][0]] = (VEC[v][1] == 0);
      idle(5);
      run_req(VEC[v][0], VEC[v][2], 8, own, other);
      chk(VEC[v][1] != 0 ? "R5 bypass length" :
          (VEC[v][2] == 1 ? "R8 short request" : "R2 single pulse"), own, VEC[v][3]);
      chk("R7 other lane quiet", other, 0);
      byp_ni = '1;
      idle(5);
    end

    // R3 latency: drive just after a falling edge, sample at the next four
    req_ni[0] = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk_i);
      chk($sformatf("R3 latency edge %0d", k), int'(strobe_no[0]), (k == 3) ? 0 : 1);
    end
    req_ni[0] = 1'b1;
    idle(6);

    // R4 one-cycle gap re-arms
    hits = 0;
    run_req(0, 6, 1, own, other); hits += own;
    run_req(0, 6, 8, own, other); hits += own;
    chk("R4 two pulses across one-cycle gap", hits, 2);
    idle(4);

    // R6 bypass release while request held
    byp_ni[1] = 1'b0;
    idle(5);
    req_ni[1] = 1'b0;
    idle(10);
    chk("R5 pass level low", int'(strobe_no[1]), 0);
    byp_ni[1] = 1'b1;
    idle(4);
    run_req(1, 10, 0, own, other);
    chk("R6 no pulse after bypass release", own, 0);
    req_ni[1] = 1'b1;
    idle(6);

    // R1 request held through reset reads as new once reset releases
    req_ni[0] = 1'b0;
    idle(2);
    rst_ni = 1'b0;
    idle(3);
    chk("R1 strobe high during reset with request", int'(strobe_no), 3);
    rst_ni = 1'b1;
    run_req(0, 10, 6, own, other);
    chk("R1 one pulse after reset release", own, 1);

    finish_run();
  end
endmodule